// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an addressing-mode code and the current register values of a 16-bit processor into a 16-bit effective offset and a 20-bit physical address. The offset is built from a pointer register (BX or BP as the base, SI or DI as the index) and a displacement, in the combination the mode selects. A segment value is picked by default from the registers the mode uses and shifted four bits left. The wrapped offset is then added to it.

The mode code also covers instruction fetch from the code segment and instruction pointer. Register values and the mode arrive as inputs each cycle. Segment override, decoding, the register file and the memory bus stay outside the block. A strobe captures one request into a registered output stage, and the result appears one clock later with a matching valid flag.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first strobe, `valid_o`, `illegal_o`, `pa_o`, `ea_o` and `seg_o` are all zero.
- R2: A request with `valid_i` high is captured on the rising clock edge, and its results appear with `valid_o` high after that edge. When `valid_i` is low, `valid_o` drops at the next edge and `pa_o`, `ea_o`, `seg_o` and `illegal_o` hold their previous values, whatever the other inputs do.
- R3: Mode code 0 (fetch) gives `ea_o` equal to `ip_i` and uses the code segment `cs_i`, with `seg_o` = 0.
- R4: Mode code 1 (direct) gives `ea_o` equal to the displacement alone and uses `ds_i`, with `seg_o` = 1.
- R5: Mode code 2 (register-indirect) gives `ea_o` equal to one register and no displacement. If `ri_idx_i` is 1, the register is the index (DI when `di_sel_i` is 1, otherwise SI). If `ri_idx_i` is 0, the register is the base (BP when `bp_sel_i` is 1, otherwise BX).
- R6: Mode code 3 (based) adds the base register to the displacement. Mode code 4 (indexed) adds the index register to the displacement.
- R7: Mode code 5 (based-indexed) adds the base register to the index register. Mode code 6 adds the base register, the index register and the displacement.
- R8: When `disp8_i` is 1, the displacement is bits 7:0 of `disp_i` sign-extended to 16 bits. When it is 0, all 16 bits of `disp_i` are used.
- R9: The default segment is `ss_i` (`seg_o` = 2) when BP is the base register actually used. In the other memory modes it is `ds_i` (`seg_o` = 1).
- R10: The offset sum wraps modulo 2^16 before the segment is added.
- R11: `pa_o` equals the segment value times 16 plus `ea_o`, taken modulo 2^20.
- R12: Mode code 7 is illegal. It gives `pa_o` = 0, `ea_o` = 0, `seg_o` = 0 and `illegal_o` = 1. Every legal code gives `illegal_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Capture strobe for the request |
| mode_i | input | 3 | Addressing-mode code (0 to 7) |
| bp_sel_i | input | 1 | Base register: 1 = BP, 0 = BX |
| di_sel_i | input | 1 | Index register: 1 = DI, 0 = SI |
| ri_idx_i | input | 1 | Register-indirect source: 1 = index, 0 = base |
| disp8_i | input | 1 | 1 = sign-extend the low displacement byte |
| disp_i | input | 16 | Displacement |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| cs_i | input | 16 | Code segment |
| ds_i | input | 16 | Data segment |
| ss_i | input | 16 | Stack segment |
| ip_i | input | 16 | Instruction pointer |
| valid_o | output | 1 | Result valid |
| pa_o | output | 20 | Physical address |
| ea_o | output | 16 | Effective offset |
| seg_o | output | 2 | Segment used: 0 code, 1 data, 2 stack |
| illegal_o | output | 1 | Mode code was illegal |

## Verification
The bench aims at an offset sum that crosses FFFFh. A design that carries that bit into the segment addition produces an address 64 KB too high. It also drives a segment near FFFFh so that the 20-bit sum overflows. A design with a wider adder would then show a nonzero high bit, or would not wrap to the bottom of the address space.

A negative byte displacement checks that sign extension is not replaced by zero extension, which would give an address 256 bytes past the correct one. BP as a base, compared with BP merely selected but not used, catches a design that picks the stack segment from the select pin rather than from the register that is actually used. Strobe-low cycles with changing inputs catch an output stage that updates without a capture.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        AM_FETCH     = 3'd0,
        AM_DIRECT    = 3'd1,
        AM_REGIND    = 3'd2,
        AM_BASED     = 3'd3,
        AM_INDEXED   = 3'd4,
        AM_BIDX      = 3'd5,
        AM_BIDX_DISP = 3'd6,
        AM_BAD       = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2
    } segsel_e;

endpackage

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
    import ea_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter int DISPB_W = 8
) (
    input  amode_e             mode,
    input  logic               bp_sel,
    input  logic               di_sel,
    input  logic               ri_idx,
    input  logic               disp8,
    input  logic [OFS_W-1:0]   disp,
    input  logic [OFS_W-1:0]   bx,
    input  logic [OFS_W-1:0]   bp,
    input  logic [OFS_W-1:0]   si,
    input  logic [OFS_W-1:0]   di,
    input  logic [OFS_W-1:0]   ip,
    output logic [OFS_W-1:0]   offset,
    output logic               uses_bp,
    output logic               illegal
);
    localparam int EXT_W = OFS_W - DISPB_W;

    logic [OFS_W-1:0] base_v;
    logic [OFS_W-1:0] idx_v;
    logic [OFS_W-1:0] dext;

    always_comb begin
        base_v = bp_sel ? bp : bx;
        idx_v  = di_sel ? di : si;
        dext   = disp8 ? {{EXT_W{disp[DISPB_W-1]}}, disp[DISPB_W-1:0]} : disp;
    end

    // Sums are truncated to OFS_W bits, which wraps the offset.
    always_comb begin
        offset  = '0;
        uses_bp = 1'b0;
        illegal = 1'b0;
        unique case (mode)
            AM_FETCH:     offset = ip;
            AM_DIRECT:    offset = dext;
            AM_REGIND: begin
                offset  = ri_idx ? idx_v : base_v;
                uses_bp = !ri_idx && bp_sel;
            end
            AM_BASED: begin
                offset  = base_v + dext;
                uses_bp = bp_sel;
            end
            AM_INDEXED:   offset = idx_v + dext;
            AM_BIDX: begin
                offset  = base_v + idx_v;
                uses_bp = bp_sel;
            end
            AM_BIDX_DISP: begin
                offset  = base_v + idx_v + dext;
                uses_bp = bp_sel;
            end
            AM_BAD:       illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
    import ea_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  amode_e           mode,
    input  logic             uses_bp,
    input  logic [SEG_W-1:0] cs,
    input  logic [SEG_W-1:0] ds,
    input  logic [SEG_W-1:0] ss,
    output logic [SEG_W-1:0] seg_val,
    output segsel_e          seg_sel
);
    always_comb begin
        unique case (mode)
            AM_FETCH, AM_BAD: seg_sel = SEG_CODE;
            default:          seg_sel = uses_bp ? SEG_STACK : SEG_DATA;
        endcase
        unique case (seg_sel)
            SEG_CODE:  seg_val = cs;
            SEG_STACK: seg_val = ss;
            default:   seg_val = ds;
        endcase
    end
endmodule

// File: rtl/ea_phys_form.sv
module ea_phys_form #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = OFS_W + SEG_SHIFT
) (
    input  logic [OFS_W-1:0] seg_val,
    input  logic [OFS_W-1:0] offset,
    input  logic             illegal,
    output logic [PA_W-1:0]  pa
);
    logic [PA_W-1:0] seg_scaled;
    logic [PA_W-1:0] ofs_ext;

    always_comb begin
        seg_scaled = {seg_val, {SEG_SHIFT{1'b0}}};
        ofs_ext    = {{SEG_SHIFT{1'b0}}, offset};
        pa         = illegal ? '0 : seg_scaled + ofs_ext;
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int DISPB_W   = 8,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = OFS_W + SEG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [2:0]       mode_i,
    input  logic             bp_sel_i,
    input  logic             di_sel_i,
    input  logic             ri_idx_i,
    input  logic             disp8_i,
    input  logic [OFS_W-1:0] disp_i,
    input  logic [OFS_W-1:0] bx_i,
    input  logic [OFS_W-1:0] bp_i,
    input  logic [OFS_W-1:0] si_i,
    input  logic [OFS_W-1:0] di_i,
    input  logic [OFS_W-1:0] cs_i,
    input  logic [OFS_W-1:0] ds_i,
    input  logic [OFS_W-1:0] ss_i,
    input  logic [OFS_W-1:0] ip_i,
    output logic             valid_o,
    output logic [PA_W-1:0]  pa_o,
    output logic [OFS_W-1:0] ea_o,
    output logic [1:0]       seg_o,
    output logic             illegal_o
);
    amode_e           mode;
    logic [OFS_W-1:0] offset;
    logic             uses_bp;
    logic             illegal;
    logic [OFS_W-1:0] seg_val;
    segsel_e          seg_sel;
    logic [PA_W-1:0]  pa;

    assign mode = amode_e'(mode_i);

    ea_offset_sum #(.OFS_W(OFS_W), .DISPB_W(DISPB_W)) u_ofs (
        .mode(mode), .bp_sel(bp_sel_i), .di_sel(di_sel_i), .ri_idx(ri_idx_i),
        .disp8(disp8_i), .disp(disp_i), .bx(bx_i), .bp(bp_i), .si(si_i),
        .di(di_i), .ip(ip_i), .offset(offset), .uses_bp(uses_bp),
        .illegal(illegal)
    );

    ea_seg_pick #(.SEG_W(OFS_W)) u_seg (
        .mode(mode), .uses_bp(uses_bp), .cs(cs_i), .ds(ds_i), .ss(ss_i),
        .seg_val(seg_val), .seg_sel(seg_sel)
    );

    ea_phys_form #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_pa (
        .seg_val(seg_val), .offset(offset), .illegal(illegal), .pa(pa)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_o      <= '0;
            ea_o      <= '0;
            seg_o     <= '0;
            illegal_o <= 1'b0;
        end else if (valid_i) begin
            pa_o      <= pa;
            ea_o      <= illegal ? '0 : offset;
            seg_o     <= seg_sel;
            illegal_o <= illegal;
        end
    end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int OFS_W = 16,
    parameter int PA_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [2:0]       mode_i,
    input logic             bp_sel_i,
    input logic             ri_idx_i,
    input logic [OFS_W-1:0] cs_i,
    input logic [OFS_W-1:0] ip_i,
    input logic             valid_o,
    input logic [PA_W-1:0]  pa_o,
    input logic [OFS_W-1:0] ea_o,
    input logic [1:0]       seg_o,
    input logic             illegal_o
);
    localparam int SHIFT = PA_W - OFS_W;

    a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(pa_o) && $stable(ea_o) && $stable(seg_o) && $stable(illegal_o)));

    a_r3_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i == 3'd0) |=>
            (ea_o == $past(ip_i) && seg_o == 2'd0 &&
             pa_o == PA_W'({$past(cs_i), {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, $past(ip_i)})));

    a_r9_stack_seg: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && bp_sel_i && (mode_i == 3'd3 || mode_i == 3'd5 || mode_i == 3'd6 ||
                                 (mode_i == 3'd2 && !ri_idx_i))) |=> seg_o == 2'd2);

    a_r12_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (pa_o == '0 && ea_o == '0 && seg_o == 2'd0));

    a_r12_flag: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (illegal_o == ($past(mode_i) == 3'd7)));
endmodule

bind ea_gen ea_gen_chk #(.OFS_W(OFS_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .bp_sel_i(bp_sel_i), .ri_idx_i(ri_idx_i), .cs_i(cs_i), .ip_i(ip_i),
    .valid_o(valid_o), .pa_o(pa_o), .ea_o(ea_o), .seg_o(seg_o),
    .illegal_o(illegal_o)
);

// File: tb/ea_gen_bench.sv
`timescale 1ns/1ps
module ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic        bp_sel_i = 1'b0, di_sel_i = 1'b0, ri_idx_i = 1'b0, disp8_i = 1'b0;
    logic [15:0] disp_i = '0, bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
    logic [15:0] cs_i = '0, ds_i = '0, ss_i = '0, ip_i = '0;
    logic        valid_o, illegal_o;
    logic [19:0] pa_o;
    logic [15:0] ea_o;
    logic [1:0]  seg_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [19:0] e_pa;
    logic [15:0] e_ea;
    logic [1:0]  e_seg;
    logic        e_bad;

    always #2.5 clk = ~clk;

    ea_gen u_ea_gen (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
        .bp_sel_i(bp_sel_i), .di_sel_i(di_sel_i), .ri_idx_i(ri_idx_i),
        .disp8_i(disp8_i), .disp_i(disp_i), .bx_i(bx_i), .bp_i(bp_i),
        .si_i(si_i), .di_i(di_i), .cs_i(cs_i), .ds_i(ds_i), .ss_i(ss_i),
        .ip_i(ip_i), .valid_o(valid_o), .pa_o(pa_o), .ea_o(ea_o),
        .seg_o(seg_o), .illegal_o(illegal_o)
    );

    task automatic expect_now();
        logic [15:0] b, x, d, s;
        logic        stk;
        b = bp_sel_i ? bp_i : bx_i;
        x = di_sel_i ? di_i : si_i;
        d = disp8_i ? {{8{disp_i[7]}}, disp_i[7:0]} : disp_i;   // R8
        stk = 1'b0;
        e_bad = 1'b0;
        case (mode_i)
            3'd0: e_ea = ip_i;
            3'd1: e_ea = d;
            3'd2: begin e_ea = ri_idx_i ? x : b; stk = !ri_idx_i && bp_sel_i; end
            3'd3: begin e_ea = b + d; stk = bp_sel_i; end
            3'd4: e_ea = x + d;
            3'd5: begin e_ea = b + x; stk = bp_sel_i; end
            3'd6: begin e_ea = b + x + d; stk = bp_sel_i; end
            default: begin e_ea = 16'h0; e_bad = 1'b1; end
        endcase
        if (mode_i == 3'd0 || e_bad) e_seg = 2'd0;
        else e_seg = stk ? 2'd2 : 2'd1;
        if (e_bad) s = 16'h0;
        else if (e_seg == 2'd0) s = cs_i;
        else if (e_seg == 2'd2) s = ss_i;
        else s = ds_i;
        e_pa = e_bad ? 20'h0 : (({4'h0, s} << 4) + {4'h0, e_ea});
    endtask

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3, 3'd4: return "R6";
            3'd5, 3'd6: return "R7";
            default: return "R12";
        endcase
    endfunction

    // Capture one request and compare the registered result one cycle later.
    task automatic run(input string rq);
        expect_now();
        valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check({rq, " valid"}, {63'h0, valid_o}, 64'h1);
        check({rq, " ea"}, {48'h0, ea_o}, {48'h0, e_ea});
        check({rq, " seg"}, {62'h0, seg_o}, {62'h0, e_seg});
        check({rq, " pa"}, {44'h0, pa_o}, {44'h0, e_pa});
        check({rq, " illegal"}, {63'h0, illegal_o}, {63'h0, e_bad});
        valid_i = 1'b0;
    endtask

    task automatic rand_inputs();
        mode_i   = 3'($urandom);
        bp_sel_i = 1'($urandom);
        di_sel_i = 1'($urandom);
        ri_idx_i = 1'($urandom);
        disp8_i  = 1'($urandom);
        disp_i = 16'($urandom); bx_i = 16'($urandom); bp_i = 16'($urandom);
        si_i = 16'($urandom);   di_i = 16'($urandom); cs_i = 16'($urandom);
        ds_i = 16'($urandom);   ss_i = 16'($urandom); ip_i = 16'($urandom);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1 valid", {63'h0, valid_o}, 64'h0);
        check("R1 pa", {44'h0, pa_o}, 64'h0);
        check("R1 ea/seg/illegal", {45'h0, ea_o, seg_o, illegal_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {43'h0, valid_o, pa_o}, 64'h0);

        // R3 fetch with literal expectation
        mode_i = 3'd0; cs_i = 16'hA820; ip_i = 16'hCE24;
        run("R3 fetch");
        check("R3 literal", {44'h0, pa_o}, 64'hB5024);

        // R11 physical wrap past 1 MB
        cs_i = 16'hFFFF; ip_i = 16'h0010;
        run("R11 wrap");
        check("R11 literal", {44'h0, pa_o}, 64'h0);

        // R10 offset wrap before segment add
        mode_i = 3'd5; bp_sel_i = 1'b0; di_sel_i = 1'b0;
        bx_i = 16'hFFFF; si_i = 16'h0002; ds_i = 16'h1000;
        run("R10 ofs wrap");
        check("R10 literal", {44'h0, pa_o}, 64'h10001);

        // R8 negative byte displacement, based on BX
        mode_i = 3'd3; disp8_i = 1'b1; disp_i = 16'h12F9; bx_i = 16'h0600; ds_i = 16'h0100;
        run("R8 sext");
        check("R8 literal", {48'h0, ea_o}, 64'h05F9);

        // R9 BP base picks stack segment; BP selected but index used stays data
        mode_i = 3'd3; bp_sel_i = 1'b1; disp8_i = 1'b0; disp_i = 16'hFFF9;
        bp_i = 16'h0012; ss_i = 16'h0A00;
        run("R9 bp stack");
        check("R9 literal", {44'h0, pa_o}, 64'h0A00B);
        mode_i = 3'd2; ri_idx_i = 1'b1; di_sel_i = 1'b1; di_i = 16'h0030; ds_i = 16'h0200;
        run("R9 index data");
        mode_i = 3'd4;
        run("R6 indexed");
        mode_i = 3'd6; ds_i = 16'h0300;
        run("R7 bidx disp");

        // R4 direct, R12 illegal
        mode_i = 3'd1; disp_i = 16'h7000; ds_i = 16'h1000;
        run("R4 direct");
        mode_i = 3'd7;
        run("R12 illegal");

        // R2 hold while strobe low
        run("R2 prime");
        for (int k = 0; k < 20; k++) begin
            logic [19:0] hp;
            logic [15:0] he;
            logic [1:0]  hs;
            logic        hi;
            hp = pa_o; he = ea_o; hs = seg_o; hi = illegal_o;
            rand_inputs();
            valid_i = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check("R2 valid low", {63'h0, valid_o}, 64'h0);
            check("R2 hold", {41'h0, pa_o, he == ea_o, hs == seg_o, hi == illegal_o},
                  {41'h0, hp, 3'b111});
            run(tag_of(mode_i));
        end

        // Constrained random across all codes
        for (int n = 0; n < 400; n++) begin
            rand_inputs();
            if (n % 8 == 0) begin
                bx_i = 16'hFF00 | bx_i; si_i = 16'hFF00 | si_i;
            end
            run(tag_of(mode_i));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule